// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall-clock time as one free-running count advanced by a slow time-base strobe (nominally 32 kHz). The count is split into a whole-seconds word and a fractional word; with the default widths the fraction is 15 bits, so one second is 32768 strobes and the complete count is 47 bits. A second register pair holds an alarm time of the same width. When an advancing strobe makes the count equal to the alarm, a sticky alarm flag is raised. That flag reaches the interrupt output when its enable bit is set.

Software reaches the block through a simple word-addressed register port. It can load the count and the alarm and can start or stop counting. It reads a status word and clears flags by writing ones to them. Counting is held off in three cases: until the seconds word has been loaded once, while the power-on invalid flag is still set, and while the run bit is clear. An alarm seconds value of all ones means no alarm is armed. Writing a zero fraction and then the seconds word loads an exact whole second.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the count and fraction read 0, the run bit (offset 0x10, bit 3) and the alarm interrupt enable (offset 0x18, bit 4) read 0, the alarm seconds (offset 0x08) read all ones, the alarm fraction (offset 0x0C) reads 0, the status word (offset 0x14) reads 0x3 (invalid flag bit 1 and violation flag bit 0 set, others clear), and `irq` is 0.
- R2: The count does not advance on any strobe until the seconds word (offset 0x00) has been written at least once since reset; fraction writes are still accepted.
- R3: While the invalid status flag (bit 1) is set, the count does not advance.
- R4: The count advances only while the run bit (offset 0x10, bit 3) is 1.
- R5: Each accepted strobe adds one to the combined count; the fraction (offset 0x04, low FRAC_W bits) carries into the seconds word (offset 0x00, low SEC_W bits).
- R6: The overflow status flag (bit 2) is set by the strobe that takes the combined count from all ones to zero.
- R7: The alarm status flag (bit 4) is set by the strobe that makes the combined count equal to the combined alarm value, and stays set while the count moves past it.
- R8: While the alarm seconds word is all ones, no strobe sets the alarm flag.
- R9: `irq` is 1 exactly when the alarm flag and the alarm interrupt enable (offset 0x18, bit 4) are both 1.
- R10: Writing the status word clears each flag whose bit is 1 and leaves flags whose bit is 0 unchanged; a flag being set in the same cycle as its clear stays set.
- R11: A write to the seconds or fraction word in the same cycle as a strobe takes the written value and the strobe is dropped; a zero fraction write followed by a seconds write S gives a count of exactly S whole seconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset for both reads and writes |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for `addr`, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench shrinks the count to 9 bits and then walks through every value. A carry or wrap error therefore shows up as a wrong value at the exact strobe where it occurs, and a missed overflow shows up as a clear flag after the wrap. Several alarm positions are tested, including ones reached only by wrapping. At each one the bench checks that the flag is clear two strobes early, set on the matching strobe and still set afterwards; a design that compared only the seconds word or treated the flag as a level would fail here. Further checks target the hold-off cases (seconds never written, invalid flag still set, run bit cleared) and the all-ones alarm that must never fire. They also cover a write racing a strobe, where a design that let the strobe win would read one count too high. The last case is a flag clear racing a flag set, where a design that let the clear win would lose the alarm.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_SEC   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_FRAC  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_ASEC  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_AFRAC = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_IE    = 6'h18;

    localparam int RUN_BIT      = 3;
    localparam int ST_ALARM_BIT = 4;
    localparam int ST_WRAP_BIT  = 2;
    localparam int ST_INVAL_BIT = 1;
    localparam int ST_VIOL_BIT  = 0;
    localparam int IE_ALARM_BIT = 4;

    typedef struct packed {
        logic alarm;
        logic wrap;
        logic inval;
        logic viol;
    } stat_t;

    typedef struct packed {
        logic sec;
        logic frac;
        logic asec;
        logic afrac;
        logic ctrl;
        logic stat;
        logic ie;
    } wsel_t;

    function automatic wsel_t decode_wr(input logic en, input logic [ADDR_W-1:0] a);
        wsel_t w;
        w.sec   = en && (a == OFF_SEC);
        w.frac  = en && (a == OFF_FRAC);
        w.asec  = en && (a == OFF_ASEC);
        w.afrac = en && (a == OFF_AFRAC);
        w.ctrl  = en && (a == OFF_CTRL);
        w.stat  = en && (a == OFF_STAT);
        w.ie    = en && (a == OFF_IE);
        return w;
    endfunction

    function automatic logic [31:0] pack_status(input stat_t s);
        logic [31:0] w;
        w = '0;
        w[ST_ALARM_BIT] = s.alarm;
        w[ST_WRAP_BIT]  = s.wrap;
        w[ST_INVAL_BIT] = s.inval;
        w[ST_VIOL_BIT]  = s.viol;
        return w;
    endfunction

endpackage

// File: rtl/rtc_count.sv
module rtc_count #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    run_en,
    input  logic                    inval,
    input  logic                    wr_sec,
    input  logic                    wr_frac,
    input  logic [31:0]             wdata,
    output logic [SEC_W+FRAC_W-1:0] cnt_q,
    output logic [SEC_W+FRAC_W-1:0] cnt_next,
    output logic                    armed_q,
    output logic                    adv,
    output logic                    wrap
);
    localparam int CNT_W = SEC_W + FRAC_W;

    logic carry;

    assign {carry, cnt_next} = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign adv  = tick && run_en && armed_q && !inval && !wr_sec && !wr_frac;
    assign wrap = adv && carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (wr_sec) begin
                cnt_q[CNT_W-1:FRAC_W] <= wdata[SEC_W-1:0];
                armed_q               <= 1'b1;
            end
            if (wr_frac)
                cnt_q[FRAC_W-1:0] <= wdata[FRAC_W-1:0];
            if (adv)
                cnt_q <= cnt_next;
        end
    end
endmodule

// File: rtl/rtc_match.sv
module rtc_match #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_asec,
    input  logic                    wr_afrac,
    input  logic [31:0]             wdata,
    input  logic                    adv,
    input  logic [SEC_W+FRAC_W-1:0] cnt_next,
    output logic [SEC_W+FRAC_W-1:0] alarm_q,
    output logic                    unset,
    output logic                    hit
);
    localparam int CNT_W = SEC_W + FRAC_W;

    assign unset = &alarm_q[CNT_W-1:FRAC_W];
    assign hit   = adv && !unset && (cnt_next == alarm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= {{SEC_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            if (wr_asec)
                alarm_q[CNT_W-1:FRAC_W] <= wdata[SEC_W-1:0];
            if (wr_afrac)
                alarm_q[FRAC_W-1:0] <= wdata[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stat,
    input  logic [31:0] wdata,
    input  logic        hit,
    input  logic        wrap,
    output stat_t       stat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '{alarm: 1'b0, wrap: 1'b0, inval: 1'b1, viol: 1'b1};
        end else begin
            if (wr_stat) begin
                if (wdata[ST_ALARM_BIT]) stat_q.alarm <= 1'b0;
                if (wdata[ST_WRAP_BIT])  stat_q.wrap  <= 1'b0;
                if (wdata[ST_INVAL_BIT]) stat_q.inval <= 1'b0;
                if (wdata[ST_VIOL_BIT])  stat_q.viol  <= 1'b0;
            end
            // a set in the same cycle overrides the clear above
            if (hit)  stat_q.alarm <= 1'b1;
            if (wrap) stat_q.wrap  <= 1'b1;
        end
    end
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
    import rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              irq
);
    localparam int CNT_W = SEC_W + FRAC_W;

    wsel_t            ws;
    logic             run_q;
    logic             ie_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] alarm_q;
    logic             armed_q;
    logic             adv;
    logic             wrap;
    logic             hit;
    logic             unset;
    stat_t            stat_q;

    assign ws = decode_wr(wr_en, addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
        end else begin
            if (ws.ctrl) run_q <= wr_data[RUN_BIT];
            if (ws.ie)   ie_q  <= wr_data[IE_ALARM_BIT];
        end
    end

    rtc_count #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run_en   (run_q),
        .inval    (stat_q.inval),
        .wr_sec   (ws.sec),
        .wr_frac  (ws.frac),
        .wdata    (wr_data),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .armed_q  (armed_q),
        .adv      (adv),
        .wrap     (wrap)
    );

    rtc_match #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .wr_asec  (ws.asec),
        .wr_afrac (ws.afrac),
        .wdata    (wr_data),
        .adv      (adv),
        .cnt_next (cnt_next),
        .alarm_q  (alarm_q),
        .unset    (unset),
        .hit      (hit)
    );

    rtc_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_stat (ws.stat),
        .wdata   (wr_data),
        .hit     (hit),
        .wrap    (wrap),
        .stat_q  (stat_q)
    );

    assign irq = stat_q.alarm && ie_q;

    always_comb begin
        rd_data = '0;
        unique case (addr)
            OFF_SEC:   rd_data[SEC_W-1:0]  = cnt_q[CNT_W-1:FRAC_W];
            OFF_FRAC:  rd_data[FRAC_W-1:0] = cnt_q[FRAC_W-1:0];
            OFF_ASEC:  rd_data[SEC_W-1:0]  = alarm_q[CNT_W-1:FRAC_W];
            OFF_AFRAC: rd_data[FRAC_W-1:0] = alarm_q[FRAC_W-1:0];
            OFF_CTRL:  rd_data[RUN_BIT]    = run_q;
            OFF_STAT:  rd_data             = pack_status(stat_q);
            OFF_IE:    rd_data[IE_ALARM_BIT] = ie_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_seconds_alarm_chk.sv
module rtc_seconds_alarm_chk
    import rtc_pkg::*;
#(
    parameter int CNT_W = 47
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wr_data,
    input logic [CNT_W-1:0]  count,
    input logic              armed,
    input logic              run_en,
    input logic              inval,
    input logic              alarm_flag,
    input logic              ie_alarm,
    input logic              alarm_unset,
    input logic              irq
);
    logic wr_cnt;
    logic clr_alarm;

    assign wr_cnt    = wr_en && (addr == OFF_SEC || addr == OFF_FRAC);
    assign clr_alarm = wr_en && (addr == OFF_STAT) && wr_data[ST_ALARM_BIT];

    // R2
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !wr_cnt) |=> $stable(count));

    // R3
    invalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inval && !wr_cnt) |=> $stable(count));

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !wr_cnt) |=> $stable(count));

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_en && armed && !inval && !wr_cnt) |=> (count == $past(count) + 1'b1));

    // R7
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !clr_alarm) |=> alarm_flag);

    // R8
    unset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> !$past(alarm_unset));

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (alarm_flag && ie_alarm));

    // R9
    irq_present_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && ie_alarm) |-> irq);
endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wr_en       (wr_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .count       (cnt_q),
    .armed       (armed_q),
    .run_en      (run_q),
    .inval       (stat_q.inval),
    .alarm_flag  (stat_q.alarm),
    .ie_alarm    (ie_q),
    .alarm_unset (unset),
    .irq         (irq)
);

// File: tb/rtc_seconds_alarm_tb.sv
module rtc_seconds_alarm_tb;
    localparam int SEC_W  = 6;
    localparam int FRAC_W = 3;
    localparam int CNT_W  = SEC_W + FRAC_W;
    localparam int MODV   = 1 << CNT_W;
    localparam int FMASK  = (1 << FRAC_W) - 1;
    localparam int SMASK  = (1 << SEC_W) - 1;

    localparam logic [5:0] A_SEC = 6'h00, A_FRAC = 6'h04, A_ASEC = 6'h08,
                           A_AFRAC = 6'h0C, A_CTRL = 6'h10, A_STAT = 6'h14, A_IE = 6'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_seconds_alarm #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_count(output int c);
        int s, f;
        rd(A_SEC, s);
        rd(A_FRAC, f);
        c = (s << FRAC_W) | f;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic tick_with_wr(input logic [5:0] a, input int d);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic load(input int v);
        wr(A_FRAC, v & FMASK);
        wr(A_SEC, (v >> FRAC_W) & SMASK);
    endtask

    task automatic set_alarm(input int v);
        wr(A_AFRAC, v & FMASK);
        wr(A_ASEC, (v >> FRAC_W) & SMASK);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, c;
        int alarms [7] = '{0, 1, 7, 8, 100, 300, 503};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, v);  chk("R1 status", v, 32'h3);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_IE, v);    chk("R1 ie", v, 0);
        rd(A_SEC, v);   chk("R1 sec", v, 0);
        rd(A_FRAC, v);  chk("R1 frac", v, 0);
        rd(A_ASEC, v);  chk("R1 alarm sec", v, SMASK);
        rd(A_AFRAC, v); chk("R1 alarm frac", v, 0);
        chk("R1 irq", irq, 0);

        // R2 not armed: run on, flags cleared, strobes ignored
        wr(A_CTRL, 32'h8);
        wr(A_STAT, 32'h3);
        rd(A_STAT, v); chk("R10 clear invalid+viol", v, 0);
        wr(A_FRAC, 5);
        tick_n(5);
        rd_count(c); chk("R2 unarmed hold", c, 5);

        // R3 invalid flag holds count; re-enter invalid via reset
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        wr(A_CTRL, 32'h8);
        wr(A_SEC, 2);
        tick_n(4);
        rd_count(c); chk("R3 invalid hold", c, 2 << FRAC_W);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R10 zero write no effect", v, 32'h3);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); chk("R10 clear invalid only", v, 32'h1);
        wr(A_STAT, 32'h1);
        tick_n(3);
        rd_count(c); chk("R5 runs after invalid clear", c, (2 << FRAC_W) + 3);

        // R4 run bit
        wr(A_CTRL, 32'h0);
        tick_n(4);
        rd_count(c); chk("R4 stopped hold", c, (2 << FRAC_W) + 3);
        wr(A_CTRL, 32'h8);
        rd(A_CTRL, v); chk("R4 run readback", v, 32'h8);

        // R11 exact load, R5 full sweep, R6 wrap, R8 unset alarm passes
        load(0);
        rd_count(c); chk("R11 exact load zero", c, 0);
        for (int k = 1; k < MODV; k++) begin
            tick_n(1);
            rd_count(c); chk("R5 sweep", c, k);
        end
        rd(A_STAT, v); chk("R6 no wrap before rollover", v & 32'h4, 0);
        tick_n(1);
        rd_count(c); chk("R6 wrapped count", c, 0);
        rd(A_STAT, v); chk("R6 wrap flag", v & 32'h4, 32'h4);
        chk("R8 unset alarm never fired", v & 32'h10, 0);
        wr(A_STAT, 32'h4);
        rd(A_STAT, v); chk("R10 wrap cleared", v, 0);

        // R7 alarm sweep, R9 irq gating, R10 clears
        foreach (alarms[i]) begin
            int a;
            a = alarms[i];
            set_alarm(a);
            load((a - 3 + MODV) % MODV);
            wr(A_STAT, 32'h1F);
            tick_n(2);
            rd(A_STAT, v); chk("R7 early no flag", v & 32'h10, 0);
            tick_n(1);
            rd_count(c); chk("R7 at alarm count", c, a);
            rd(A_STAT, v); chk("R7 flag on match", v & 32'h10, 32'h10);
            chk("R9 irq masked", irq, 0);
            tick_n(2);
            rd(A_STAT, v); chk("R7 sticky past alarm", v & 32'h10, 32'h10);
            wr(A_IE, 32'h10);
            #1; chk("R9 irq enabled", irq, 1);
            wr(A_STAT, 32'h0);
            rd(A_STAT, v); chk("R10 zero keeps alarm", v & 32'h10, 32'h10);
            wr(A_STAT, 32'h10);
            rd(A_STAT, v); chk("R10 alarm cleared", v & 32'h10, 0);
            #1; chk("R9 irq drops", irq, 0);
            wr(A_IE, 32'h0);
        end

        // R8 explicit: seconds all ones, alarm fraction 2, pass through it
        set_alarm((SMASK << FRAC_W) | 2);
        load(SMASK << FRAC_W);
        wr(A_STAT, 32'h1F);
        tick_n(5);
        rd_count(c); chk("R8 count moved", c, (SMASK << FRAC_W) + 5);
        rd(A_STAT, v); chk("R8 no alarm when unset", v & 32'h10, 0);

        // R10 set wins over same-cycle clear
        set_alarm(77);
        load(76);
        wr(A_STAT, 32'h1F);
        tick_with_wr(A_STAT, 32'h10);
        rd(A_STAT, v); chk("R10 set beats clear", v & 32'h10, 32'h10);

        // R11 write racing a strobe
        load(40);
        tick_with_wr(A_SEC, 7);
        rd_count(c); chk("R11 seconds write wins", c, 7 << FRAC_W);
        tick_with_wr(A_FRAC, 3);
        rd_count(c); chk("R11 fraction write wins", c, (7 << FRAC_W) | 3);
        tick_n(1);
        rd_count(c); chk("R5 resumes after race", c, (7 << FRAC_W) | 4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule